// File: doc/BRIEF.md
# Scanline Video Memory Slot Scheduler

This block decides, for every access window of a scanline, what the video memory cycle is spent on. A line is cut into 172 windows. A window counter steps once per internal access clock enable. For each window the block drives a command code. The code says whether the cycle belongs to the host (an external slot), to DRAM refresh, or to a tile fetch. For tile fetches the block also gives the memory address and the column being fetched. Fetched data is not stored here: the block only raises write strobes so that a line buffer elsewhere can capture the returned byte.

There are two line kinds. A refresh line is used for border and blanking rows. It opens with a run of host windows, then alternates refresh and host windows to the end of the line. A text line is used for the 40-column text display. It opens with a longer host run, then fetches 40 columns, three windows each, and closes with a short host run. The line kind and the row number are captured as the counter leaves window 0. Within one line they stay fixed.

The state machine has seven states:
- `S_HEAD`: the opening host run.
- `S_RFSH`: a refresh window.
- `S_RFSH_EXT`: the host window that follows each refresh.
- `S_NAME`: the name fetch of a column.
- `S_GAP`: the host window between the name fetch and the pattern fetch.
- `S_PAT`: the pattern fetch of a column.
- `S_TAIL`: the closing host run of a text line.

Transitions happen only on an access clock enable:
- `S_HEAD` goes to `S_RFSH` after window 43 on a refresh line.
- `S_HEAD` goes to `S_NAME` after window 46 on a text line.
- `S_RFSH` goes to `S_RFSH_EXT`.
- `S_RFSH_EXT` goes to `S_RFSH`, or to `S_HEAD` after window 171.
- `S_NAME` goes to `S_GAP`, and `S_GAP` goes to `S_PAT`.
- `S_PAT` goes to `S_NAME`, or to `S_TAIL` after window 166.
- `S_TAIL` goes to `S_HEAD` after window 171.

Top module: `line_slot_sched`

## Requirements
- R1: After reset the window index is 0, the command is external (code 2'b00), host_slot is 1 and host_column is 0.
- R2: The window index advances by one only on a cycle with slot_tick high, holds otherwise, and wraps from 171 to 0.
- R3: On a refresh line (line_text=0), windows 0 to 43 are external (2'b00). From window 44 to 171, even windows are refresh (2'b01) and odd windows are external.
- R4: On a text line (line_text=1), windows 0 to 46 and 167 to 171 are external.
- R5: On a text line, window 47+3k (k from 0 to 39) is a name fetch (2'b10) for column k. Window 48+3k is external. Window 49+3k is a pattern fetch (2'b11) for column k. col_idx shows k on both fetch windows.
- R6: During a name fetch, mem_addr equals (name_base AND (0x3C00 OR (row/8)*40)) plus the column, kept to 14 bits.
- R7: During a pattern fetch, mem_addr equals (gen_base AND (0x3800 OR row mod 8)) plus eight times the byte on mem_rdata during that column's name fetch, kept to 14 bits.
- R8: host_slot is 1 exactly in external windows, and host_column then equals twice the window index.
- R9: line_text and line_row are sampled on the tick that leaves window 0. Changing them later in the line has no effect on that line's commands or addresses.
- R10: name_we is high exactly on cycles that are both a name fetch window and have slot_tick high. pat_we does the same for pattern fetch windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_tick | input | 1 | Access clock enable; one window per high cycle |
| line_text | input | 1 | Line kind for the next line: 1 text, 0 refresh |
| line_row | input | 9 | Row number for the next line |
| name_base | input | 14 | Name table base address |
| gen_base | input | 14 | Pattern generator base address |
| mem_rdata | input | 8 | Byte returned by video memory for mem_addr |
| win_idx | output | 8 | Current access window |
| slot_cmd | output | 2 | Window use: 00 external, 01 refresh, 10 name, 11 pattern |
| host_slot | output | 1 | Current window is a host slot |
| host_column | output | 9 | Host slot column, twice the window index |
| col_idx | output | 6 | Text column being fetched |
| mem_addr | output | 14 | Fetch address (0 outside fetch windows) |
| name_we | output | 1 | Name capture strobe |
| pat_we | output | 1 | Pattern capture strobe |

## Verification
The bench walks the full boundaries of each line kind. These are the last opening host window (43 or 46), the first refresh at 44, the first name fetch at 47, the last pattern fetch at 166 and the wrap after 171. An off-by-one in any of them shifts the whole schedule by a window. The bench changes the line kind and row in the middle of a line, so a design that samples them live would switch schedule or address partway through. It stalls the enable on a name fetch window, which catches a design that fires the strobe or latches the name without a tick. It also uses all-ones bases with the largest row, where a carry or a wrong mask shows up in the address.

// File: rtl/line_slot_pkg.sv
package line_slot_pkg;

    localparam int LS_WINDOWS    = 172;
    localparam int LS_RFSH_HEAD  = 44;
    localparam int LS_TEXT_HEAD  = 47;
    localparam int LS_TEXT_COLS  = 40;
    localparam int LS_ADDR_W     = 14;
    localparam logic [LS_ADDR_W-1:0] LS_NAME_MASK = 14'h3C00;
    localparam logic [LS_ADDR_W-1:0] LS_GEN_MASK  = 14'h3800;

    typedef enum logic [1:0] {
        CMD_EXT  = 2'b00,
        CMD_RFSH = 2'b01,
        CMD_NAME = 2'b10,
        CMD_PAT  = 2'b11
    } slot_cmd_t;

    typedef enum logic [2:0] {
        S_HEAD,
        S_RFSH,
        S_RFSH_EXT,
        S_NAME,
        S_GAP,
        S_PAT,
        S_TAIL
    } slot_state_t;

endpackage

// File: rtl/lsched_window_ctr.sv
module lsched_window_ctr #(
    parameter int WINDOWS = 172,
    localparam int WIN_W = $clog2(WINDOWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [WIN_W-1:0] win,
    output logic             at_first,
    output logic             at_last
);
    localparam logic [WIN_W-1:0] LAST = WIN_W'(WINDOWS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win <= '0;
        end else if (tick) begin
            if (win == LAST) win <= '0;
            else             win <= win + 1'b1;
        end
    end

    assign at_first = (win == '0);
    assign at_last  = (win == LAST);

    // R2: wrap after the final window
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_last) |=> (win == '0));

    // R2: no movement without an enable
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(win));

endmodule

// File: rtl/lsched_slot_fsm.sv
module lsched_slot_fsm
    import line_slot_pkg::*;
#(
    parameter int WINDOWS   = LS_WINDOWS,
    parameter int RFSH_HEAD = LS_RFSH_HEAD,
    parameter int TEXT_HEAD = LS_TEXT_HEAD,
    parameter int TEXT_COLS = LS_TEXT_COLS,
    localparam int WIN_W = $clog2(WINDOWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line_text,
    input  logic [WIN_W-1:0] win,
    input  logic             at_first,
    input  logic             at_last,
    output logic [1:0]       cmd,
    output logic             host_slot,
    output logic             name_we,
    output logic             pat_we
);
    localparam int TEXT_END = TEXT_HEAD + 3 * TEXT_COLS - 1;
    localparam logic [WIN_W-1:0] RFSH_HEAD_LAST = WIN_W'(RFSH_HEAD - 1);
    localparam logic [WIN_W-1:0] TEXT_HEAD_LAST = WIN_W'(TEXT_HEAD - 1);
    localparam logic [WIN_W-1:0] TEXT_END_W     = WIN_W'(TEXT_END);

    slot_state_t state_q, state_d;
    logic        text_q;

    // line kind is captured on the tick that leaves window 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 text_q <= 1'b0;
        else if (tick && at_first)  text_q <= line_text;
    end

    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                S_HEAD: begin
                    if (at_first) begin
                        if (line_text && TEXT_HEAD == 1)       state_d = S_NAME;
                        else if (!line_text && RFSH_HEAD == 1) state_d = S_RFSH;
                    end else if (text_q && win == TEXT_HEAD_LAST) begin
                        state_d = S_NAME;
                    end else if (!text_q && win == RFSH_HEAD_LAST) begin
                        state_d = S_RFSH;
                    end
                end
                S_RFSH:     state_d = S_RFSH_EXT;
                S_RFSH_EXT: state_d = at_last ? S_HEAD : S_RFSH;
                S_NAME:     state_d = S_GAP;
                S_GAP:      state_d = S_PAT;
                S_PAT:      state_d = (win == TEXT_END_W) ? S_TAIL : S_NAME;
                S_TAIL:     state_d = at_last ? S_HEAD : S_TAIL;
                default:    state_d = S_HEAD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HEAD;
        else        state_q <= state_d;
    end

    always_comb begin
        cmd       = CMD_EXT;
        host_slot = 1'b0;
        name_we   = 1'b0;
        pat_we    = 1'b0;
        unique case (state_q)
            S_HEAD, S_RFSH_EXT, S_GAP, S_TAIL: begin
                cmd       = CMD_EXT;
                host_slot = 1'b1;
            end
            S_RFSH: cmd = CMD_RFSH;
            S_NAME: begin
                cmd     = CMD_NAME;
                name_we = tick;
            end
            S_PAT: begin
                cmd    = CMD_PAT;
                pat_we = tick;
            end
            default: begin
                cmd       = CMD_EXT;
                host_slot = 1'b1;
            end
        endcase
    end

    // R3: a refresh window is always followed by a host window
    p_rfsh_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q == S_RFSH) |=> (state_q == S_RFSH_EXT));

    // R5: a name fetch is followed by the gap window
    p_name_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q == S_NAME) |=> (state_q == S_GAP));

    // R4: the closing host run lies past the fetch region
    p_tail_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TAIL) |-> (win > TEXT_END_W));

    // R3: refresh windows occur only on even window numbers
    p_rfsh_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RFSH) |-> (win[0] == 1'b0));

endmodule

// File: rtl/lsched_fetch_addr.sv
module lsched_fetch_addr
    import line_slot_pkg::*;
#(
    parameter int ADDR_W    = LS_ADDR_W,
    parameter int DATA_W    = 8,
    parameter int ROW_W     = 9,
    parameter int TEXT_COLS = LS_TEXT_COLS,
    localparam int COL_W = $clog2(TEXT_COLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              at_first,
    input  logic [ROW_W-1:0]  line_row,
    input  logic [ADDR_W-1:0] name_base,
    input  logic [ADDR_W-1:0] gen_base,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [1:0]        cmd,
    output logic [COL_W-1:0]  col_idx,
    output logic [ADDR_W-1:0] mem_addr
);
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [DATA_W-1:0] name_q;
    logic [ADDR_W-1:0] row_term, name_addr, pat_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            name_q <= '0;
        end else if (tick) begin
            if (at_first) begin
                row_q <= line_row;
                col_q <= '0;
            end else if (cmd == CMD_PAT) begin
                col_q <= col_q + 1'b1;
            end
            if (cmd == CMD_NAME) name_q <= mem_rdata;
        end
    end

    always_comb begin
        row_term  = ADDR_W'(row_q >> 3) * ADDR_W'(TEXT_COLS);
        name_addr = (name_base & (LS_NAME_MASK | row_term)) + ADDR_W'(col_q);
        pat_addr  = (gen_base & (LS_GEN_MASK | ADDR_W'(row_q[2:0])))
                  + (ADDR_W'(name_q) << 3);
        unique case (cmd)
            CMD_NAME: mem_addr = name_addr;
            CMD_PAT:  mem_addr = pat_addr;
            default:  mem_addr = '0;
        endcase
    end

    assign col_idx = col_q;

    // R5: column index does not move between name fetch and the gap
    p_col_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cmd == CMD_NAME) |=> $stable(col_q));

endmodule

// File: rtl/line_slot_sched.sv
module line_slot_sched
    import line_slot_pkg::*;
#(
    parameter int WINDOWS   = LS_WINDOWS,
    parameter int RFSH_HEAD = LS_RFSH_HEAD,
    parameter int TEXT_HEAD = LS_TEXT_HEAD,
    parameter int TEXT_COLS = LS_TEXT_COLS,
    parameter int ADDR_W    = LS_ADDR_W,
    parameter int DATA_W    = 8,
    parameter int ROW_W     = 9,
    localparam int WIN_W = $clog2(WINDOWS),
    localparam int COL_W = $clog2(TEXT_COLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_tick,
    input  logic              line_text,
    input  logic [ROW_W-1:0]  line_row,
    input  logic [ADDR_W-1:0] name_base,
    input  logic [ADDR_W-1:0] gen_base,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [WIN_W-1:0]  win_idx,
    output logic [1:0]        slot_cmd,
    output logic              host_slot,
    output logic [WIN_W:0]    host_column,
    output logic [COL_W-1:0]  col_idx,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              name_we,
    output logic              pat_we
);
    logic at_first, at_last;

    lsched_window_ctr #(.WINDOWS(WINDOWS)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (slot_tick),
        .win      (win_idx),
        .at_first (at_first),
        .at_last  (at_last)
    );

    lsched_slot_fsm #(
        .WINDOWS   (WINDOWS),
        .RFSH_HEAD (RFSH_HEAD),
        .TEXT_HEAD (TEXT_HEAD),
        .TEXT_COLS (TEXT_COLS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (slot_tick),
        .line_text (line_text),
        .win       (win_idx),
        .at_first  (at_first),
        .at_last   (at_last),
        .cmd       (slot_cmd),
        .host_slot (host_slot),
        .name_we   (name_we),
        .pat_we    (pat_we)
    );

    lsched_fetch_addr #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .ROW_W     (ROW_W),
        .TEXT_COLS (TEXT_COLS)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (slot_tick),
        .at_first  (at_first),
        .line_row  (line_row),
        .name_base (name_base),
        .gen_base  (gen_base),
        .mem_rdata (mem_rdata),
        .cmd       (slot_cmd),
        .col_idx   (col_idx),
        .mem_addr  (mem_addr)
    );

    assign host_column = {win_idx, 1'b0};

    // R5: a fetch never names a column outside the text width
    p_col_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_cmd == CMD_NAME || slot_cmd == CMD_PAT) |-> (col_idx < COL_W'(TEXT_COLS)));

    // R1: reset leaves the counter on window 0 in a host slot
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (win_idx == '0 && host_slot));

endmodule

// File: tb/line_slot_sched_tb.sv
module line_slot_sched_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_tick = 1'b0;
    logic        line_text = 1'b0;
    logic [8:0]  line_row = '0;
    logic [13:0] name_base = '0;
    logic [13:0] gen_base = '0;
    logic [7:0]  mem_rdata;
    logic [7:0]  win_idx;
    logic [1:0]  slot_cmd;
    logic        host_slot;
    logic [8:0]  host_column;
    logic [5:0]  col_idx;
    logic [13:0] mem_addr;
    logic        name_we, pat_we;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: byte depends on address
    function automatic logic [7:0] memf(input logic [13:0] a);
        return a[7:0] ^ {a[13:8], 2'b01};
    endfunction
    assign mem_rdata = memf(mem_addr);

    line_slot_sched u_dut (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .line_text(line_text),
        .line_row(line_row), .name_base(name_base), .gen_base(gen_base),
        .mem_rdata(mem_rdata), .win_idx(win_idx), .slot_cmd(slot_cmd),
        .host_slot(host_slot), .host_column(host_column), .col_idx(col_idx),
        .mem_addr(mem_addr), .name_we(name_we), .pat_we(pat_we)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (window %0d)", req, what, act, exp, win_idx);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cycles++;
    endtask

    function automatic int exp_cmd(input bit txt, input int w);
        if (!txt) return (w < 44) ? 0 : ((w % 2 == 0) ? 1 : 0);
        if (w < 47 || w > 166) return 0;
        case ((w - 47) % 3)
            0: return 2;
            1: return 0;
            default: return 3;
        endcase
    endfunction

    // checks every window of one line; starts and ends at window 0 at a negedge
    task automatic run_line(input bit txt, input int row, input int nb, input int gb,
                            input bit disturb);
        int name_v = 0;
        line_text = txt;
        line_row  = 9'(row);
        name_base = 14'(nb);
        gen_base  = 14'(gb);
        slot_tick = 1'b1;
        for (int w = 0; w < 172; w++) begin
            int ec, col;
            ec = exp_cmd(txt, w);
            chk("R2", "window", int'(win_idx), w);
            if (txt) chk("R4/R5", "cmd", int'(slot_cmd), ec);
            else     chk("R3", "cmd", int'(slot_cmd), ec);
            chk("R8", "host_slot", int'(host_slot), (ec == 0) ? 1 : 0);
            if (ec == 0) chk("R8", "host_column", int'(host_column), 2 * w);
            chk("R10", "name_we", int'(name_we), (ec == 2) ? 1 : 0);
            chk("R10", "pat_we", int'(pat_we), (ec == 3) ? 1 : 0);
            if (ec == 2) begin
                int ea;
                col = (w - 47) / 3;
                chk("R5", "col_idx", int'(col_idx), col);
                ea = ((nb & (16'h3C00 | ((row / 8) * 40))) + col) & 16'h3FFF;
                chk("R6", "name addr", int'(mem_addr), ea);
                name_v = int'(memf(14'(ea)));
            end
            if (ec == 3) begin
                col = (w - 47) / 3;
                chk("R5", "col_idx", int'(col_idx), col);
                chk("R7", "pattern addr", int'(mem_addr),
                    ((gb & (16'h3800 | (row % 8))) + name_v * 8) & 16'h3FFF);
            end
            if (disturb && w == 1) begin
                // R9: inputs moved after window 0 must not matter this line
                line_text = ~txt;
                line_row  = 9'(row + 13);
            end
            step();
        end
        chk("R2", "wrap to 0", int'(win_idx), 0);
    endtask

    task automatic t_reset();
        chk("R1", "window", int'(win_idx), 0);
        chk("R1", "cmd", int'(slot_cmd), 0);
        chk("R1", "host_slot", int'(host_slot), 1);
        chk("R1", "host_column", int'(host_column), 0);
    endtask

    task automatic t_hold_at_zero();
        slot_tick = 1'b0;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R2", "hold at 0", int'(win_idx), 0);
        end
    endtask

    task automatic t_refresh_lines();
        run_line(1'b0, 200, 14'h1234, 14'h2345, 1'b0);
        run_line(1'b0, 0, 14'h3FFF, 14'h3FFF, 1'b0);
    endtask

    task automatic t_text_lines();
        run_line(1'b1, 37, 14'h3FFF, 14'h3FFF, 1'b0);
        run_line(1'b1, 191, 14'h3FFF, 14'h3FFF, 1'b0);
        run_line(1'b1, 0, 14'h2C15, 14'h1A07, 1'b0);
        run_line(1'b1, 84, 14'h0400, 14'h3800, 1'b0);
    endtask

    task automatic t_midline_change();
        run_line(1'b1, 58, 14'h3FFF, 14'h3FFF, 1'b1);
        run_line(1'b0, 9, 14'h3FFF, 14'h3FFF, 1'b1);
    endtask

    task automatic t_stall_on_name();
        line_text = 1'b1;
        line_row  = 9'd5;
        slot_tick = 1'b1;
        for (int i = 0; i < 47; i++) step();
        slot_tick = 1'b0;
        #1;
        chk("R10", "name_we without tick", int'(name_we), 0);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R2", "stalled window", int'(win_idx), 47);
            chk("R5", "stalled cmd", int'(slot_cmd), 2);
            chk("R10", "name_we stalled", int'(name_we), 0);
        end
        slot_tick = 1'b1;
        #1;
        chk("R10", "name_we with tick", int'(name_we), 1);
        for (int i = 47; i < 172; i++) step();
        chk("R2", "wrap after stall", int'(win_idx), 0);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            if (cycles > 100000 && !done) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold_at_zero();
        t_refresh_lines();
        t_text_lines();
        t_midline_change();
        t_stall_on_name();
        run_line(1'b0, 3, 14'h0, 14'h0, 1'b0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule